// File: doc/BRIEF.md
# Dual-Plane Pixel Palette Mapper

This block turns each 8-bit video byte into a 24-bit RGB color. The byte holds two overlaid planes. The upper five bits are a static graphics code and the lower three bits are a dynamic waveform code. Each plane has its own writable color table. A static code of zero is transparent, so the dynamic plane's color shows through wherever the static plane is empty. Any nonzero static code wins over the dynamic plane.

A host loads the table entries through a simple write port. It chooses the table with one select bit and gives a 5-bit index and a 24-bit color. Pixels arrive with a valid flag and a display-enable flag. The block registers the mapped color once and delays both flags by the same cycle, so all three stay aligned. Alongside the full-width color it gives three 6-bit channel values for external converters.

Top module: `pix_palette_map`

## Requirements
- R1: While `rst_ni` is low, `rgb_o`, every DAC output, `rgb_valid_o` and `rgb_de_o` are zero. After reset every table entry reads as zero.
- R2: When the static field `pix_i[7:3]` is nonzero, the output color is static table entry `pix_i[7:3]`.
- R3: When `pix_i[7:3]` is zero, the output color is dynamic table entry `pix_i[2:0]`.
- R4: The color for a pixel presented at clock edge t appears on `rgb_o` after edge t. `rgb_valid_o` and `rgb_de_o` equal `pix_valid_i` and `pix_de_i` delayed by one clock.
- R5: A write happens on any clock edge where `wr_en_i` is high.
  - `wr_sel_i`=0 writes static entry `wr_idx_i`.
  - `wr_sel_i`=1 writes dynamic entry `wr_idx_i[2:0]`.
  - `wr_idx_i[4:3]` has no effect on a dynamic write.
- R6: A new entry value is used from the clock after its write. A pixel presented on the same edge as a write to the entry it reads gets the old value.
- R7: A write to static entry 0 has no effect on any output color.
- R8: `rgb_o` is packed {red[23:16], green[15:8], blue[7:0]}. `dac_r_o`, `dac_g_o` and `dac_b_o` are the upper six bits of red, green and blue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_sel_i | input | 1 | Table select: 0 static, 1 dynamic |
| wr_idx_i | input | 5 | Entry index |
| wr_data_i | input | 24 | Color to write, {R,G,B} |
| pix_i | input | 8 | Video byte: static code [7:3], dynamic code [2:0] |
| pix_valid_i | input | 1 | Pixel valid |
| pix_de_i | input | 1 | Display enable |
| rgb_o | output | 24 | Mapped color, {R,G,B} |
| rgb_valid_o | output | 1 | Delayed pixel valid |
| rgb_de_o | output | 1 | Delayed display enable |
| dac_r_o | output | 6 | Red converter value |
| dac_g_o | output | 6 | Green converter value |
| dac_b_o | output | 6 | Blue converter value |

## Verification
A host write and a pixel lookup of the same entry can fall on the same clock edge. The bench provokes this by driving, in one cycle, a static entry rewrite and a pixel that selects that entry. It expects the old color on the following cycle and the new color once the pixel is presented again. The bench also drives a dynamic write with its upper index bits set, and a write to static entry 0, while pixels keep flowing. It judges both from the mapped colors that follow.

// File: rtl/pix_palette_pkg.sv
package pix_palette_pkg;
  localparam int unsigned STAT_W = 5;
  localparam int unsigned DYN_W  = 3;
  localparam int unsigned CH_W   = 8;
  localparam int unsigned DAC_W  = 6;
endpackage

// File: rtl/palette_ram.sv
module palette_ram #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned DW    = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // read of current contents: a same-edge write is seen next cycle
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/plane_mux.sv
module plane_mux #(
  parameter int unsigned CODE_W = 5,
  parameter int unsigned DW     = 24
) (
  input  logic [CODE_W-1:0] stat_code_i,
  input  logic [DW-1:0]     stat_col_i,
  input  logic [DW-1:0]     dyn_col_i,
  output logic [DW-1:0]     col_o
);
  always_comb begin
    if (stat_code_i == '0) col_o = dyn_col_i;
    else                   col_o = stat_col_i;
  end
endmodule

// File: rtl/dac_trunc.sv
module dac_trunc #(
  parameter int unsigned CH_W  = 8,
  parameter int unsigned DAC_W = 6,
  parameter int unsigned N_CH  = 3
) (
  input  logic [N_CH*CH_W-1:0]  col_i,
  output logic [N_CH*DAC_W-1:0] dac_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign dac_o[c*DAC_W +: DAC_W] = col_i[c*CH_W + CH_W - DAC_W +: DAC_W];
  end
endmodule

// File: rtl/pix_palette_map.sv
module pix_palette_map
  import pix_palette_pkg::*;
#(
  parameter int unsigned SW = STAT_W,
  parameter int unsigned DW_CODE = DYN_W,
  parameter int unsigned CW = CH_W,
  parameter int unsigned AW = DAC_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  wr_sel_i,
  input  logic [SW-1:0]         wr_idx_i,
  input  logic [3*CW-1:0]       wr_data_i,
  input  logic [SW+DW_CODE-1:0] pix_i,
  input  logic                  pix_valid_i,
  input  logic                  pix_de_i,
  output logic [3*CW-1:0]       rgb_o,
  output logic                  rgb_valid_o,
  output logic                  rgb_de_o,
  output logic [AW-1:0]         dac_r_o,
  output logic [AW-1:0]         dac_g_o,
  output logic [AW-1:0]         dac_b_o
);
  localparam int unsigned COL_W = 3 * CW;
  localparam int unsigned PIX_W = SW + DW_CODE;
  localparam int unsigned S_DEP = 1 << SW;
  localparam int unsigned D_DEP = 1 << DW_CODE;

  logic [SW-1:0]      stat_code;
  logic [DW_CODE-1:0] dyn_code;
  logic               we_stat, we_dyn;
  logic [COL_W-1:0]   stat_col, dyn_col, mix_col;
  logic [COL_W-1:0]   rgb_q;
  logic               valid_q, de_q;
  logic [3*AW-1:0]    dac_all;

  assign stat_code = pix_i[PIX_W-1:DW_CODE];
  assign dyn_code  = pix_i[DW_CODE-1:0];

  // static entry 0 is transparent and never stored
  assign we_stat = wr_en_i && !wr_sel_i && (wr_idx_i != '0);
  assign we_dyn  = wr_en_i && wr_sel_i;

  palette_ram #(.DEPTH(S_DEP), .IDX_W(SW), .DW(COL_W)) u_stat_tab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_stat),
    .waddr_i (wr_idx_i),
    .wdata_i (wr_data_i),
    .raddr_i (stat_code),
    .rdata_o (stat_col)
  );

  palette_ram #(.DEPTH(D_DEP), .IDX_W(DW_CODE), .DW(COL_W)) u_dyn_tab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_dyn),
    .waddr_i (wr_idx_i[DW_CODE-1:0]),
    .wdata_i (wr_data_i),
    .raddr_i (dyn_code),
    .rdata_o (dyn_col)
  );

  plane_mux #(.CODE_W(SW), .DW(COL_W)) u_mux (
    .stat_code_i (stat_code),
    .stat_col_i  (stat_col),
    .dyn_col_i   (dyn_col),
    .col_o       (mix_col)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_q   <= '0;
      valid_q <= 1'b0;
      de_q    <= 1'b0;
    end else begin
      rgb_q   <= mix_col;
      valid_q <= pix_valid_i;
      de_q    <= pix_de_i;
    end
  end

  dac_trunc #(.CH_W(CW), .DAC_W(AW), .N_CH(3)) u_dac (
    .col_i (rgb_q),
    .dac_o (dac_all)
  );

  assign rgb_o       = rgb_q;
  assign rgb_valid_o = valid_q;
  assign rgb_de_o    = de_q;
  assign dac_b_o     = dac_all[AW-1:0];
  assign dac_g_o     = dac_all[2*AW-1:AW];
  assign dac_r_o     = dac_all[3*AW-1:2*AW];
endmodule

// File: rtl/pix_palette_map_chk.sv
module pix_palette_map_chk #(
  parameter int unsigned SW = 5,
  parameter int unsigned DW_CODE = 3,
  parameter int unsigned CW = 8,
  parameter int unsigned AW = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic                  wr_sel_i,
  input logic [SW-1:0]         wr_idx_i,
  input logic [3*CW-1:0]       wr_data_i,
  input logic [SW+DW_CODE-1:0] pix_i,
  input logic                  pix_valid_i,
  input logic                  pix_de_i,
  input logic [3*CW-1:0]       rgb_o,
  input logic                  rgb_valid_o,
  input logic                  rgb_de_o,
  input logic [AW-1:0]         dac_r_o,
  input logic [AW-1:0]         dac_g_o,
  input logic [AW-1:0]         dac_b_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (rgb_o == '0 && !rgb_valid_o && !rgb_de_o &&
                                dac_r_o == '0 && dac_g_o == '0 && dac_b_o == '0);
    end
  end

  a_r4_valid_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |=> rgb_valid_o);
  a_r4_valid_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> !rgb_valid_o);
  a_r4_de_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rgb_de_o == $past(pix_de_i)));
  a_r8_dac_slice: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_r_o == rgb_o[3*CW-1 -: AW] && dac_g_o == rgb_o[2*CW-1 -: AW] &&
    dac_b_o == rgb_o[CW-1 -: AW]);
  // R6: with no write and a repeated pixel, the color does not change
  a_r6_stable_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && $stable(pix_i) && !$past(wr_en_i)) |=> $stable(rgb_o));
endmodule

bind pix_palette_map pix_palette_map_chk #(
  .SW(SW), .DW_CODE(DW_CODE), .CW(CW), .AW(AW)
) u_chk (.*);

// File: tb/pix_palette_map_bench.sv
`timescale 1ns/1ps
module pix_palette_map_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [4:0]  wr_idx_i = '0;
  logic [23:0] wr_data_i = '0;
  logic [7:0]  pix_i = '0;
  logic        pix_valid_i = 1'b0, pix_de_i = 1'b0;
  logic [23:0] rgb_o;
  logic        rgb_valid_o, rgb_de_o;
  logic [5:0]  dac_r_o, dac_g_o, dac_b_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [23:0] m_stat [32];
  logic [23:0] m_dyn  [8];

  always #2.5 clk_i = ~clk_i;

  pix_palette_map u_pix_palette_map (.*);

  function automatic logic [23:0] expect_col(logic [7:0] p);
    if (p[7:3] == 5'd0) return m_dyn[p[2:0]];
    return m_stat[p[7:3]];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(logic sel, logic [4:0] idx, logic [23:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_idx_i = idx; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (sel) m_dyn[idx[2:0]] = d;
    else if (idx != 0) m_stat[idx] = d;
  endtask

  // drive pixel, check result one clock later
  task automatic show(logic [7:0] p, logic v, logic de, string req);
    logic [23:0] e;
    pix_i = p; pix_valid_i = v; pix_de_i = de;
    e = expect_col(p);
    @(negedge clk_i);
    check(req, {8'h0, rgb_o}, {8'h0, e});
    check("R8", {14'h0, dac_r_o, dac_g_o, dac_b_o},
          {14'h0, e[23:18], e[15:10], e[7:2]});
    check("R4", {30'h0, rgb_valid_o, rgb_de_o}, {30'h0, v, de});
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_stat[i] = '0;
    for (int i = 0; i < 8; i++) m_dyn[i] = '0;
    repeat (3) @(negedge clk_i);
    check("R1", {2'b0, rgb_valid_o, rgb_de_o, rgb_o, dac_r_o[5:0] != 0},
          32'h0);
    check("R1", {14'h0, dac_r_o, dac_g_o, dac_b_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    show(8'h48, 1'b1, 1'b1, "R1");  // static 9 after reset = 0
    show(8'h05, 1'b0, 1'b1, "R1");  // dynamic 5 after reset = 0
    for (int i = 1; i < 32; i++)
      write(1'b0, 5'(i), {8'(i * 7 + 3), 8'(255 - i * 5), 8'(i * 33)});
    for (int j = 0; j < 8; j++)
      write(1'b1, 5'(j), {8'(200 - j * 11), 8'(j * 29 + 1), 8'(j * 61 + 7)});
    for (int p = 0; p < 256; p++)
      show(8'(p), p[0], p[1] ^ p[7], (p < 8) ? "R3" : "R2");
    // R5: upper index bits ignored on dynamic write
    write(1'b1, 5'b11010, 24'hA5C3E1);
    show(8'h02, 1'b1, 1'b0, "R5");
    show(8'h12, 1'b1, 1'b0, "R5");
    // R7: write to static entry 0 leaves transparency intact
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_idx_i = 5'd0; wr_data_i = 24'hFFFFFF;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    for (int j = 0; j < 8; j++) show(8'(j), 1'b1, 1'b1, "R7");
    // R6: write and lookup of same entry on one edge
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_idx_i = 5'd5; wr_data_i = 24'h123456;
    pix_i = 8'h2B; pix_valid_i = 1'b1; pix_de_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check("R6", {8'h0, rgb_o}, {8'h0, m_stat[5]});
    m_stat[5] = 24'h123456;
    show(8'h2B, 1'b1, 1'b1, "R6");
    // R6: dynamic same-edge case
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_idx_i = 5'd6; wr_data_i = 24'h0F0F0F;
    pix_i = 8'h06;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check("R6", {8'h0, rgb_o}, {8'h0, m_dyn[6]});
    m_dyn[6] = 24'h0F0F0F;
    show(8'h06, 1'b0, 1'b0, "R6");
    // R1: asynchronous reset clears outputs
    #1 rst_ni = 1'b0;
    #1 check("R1", {6'h0, rgb_valid_o, rgb_de_o, rgb_o}, 32'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule